// File: doc/BRIEF.md
# Sub-word register write bridge

This bridge sits between a host bus and a peripheral register file. The host bus issues 8-, 16- and 32-bit register reads and writes. The register file accepts only aligned 32-bit reads and writes. A narrow read fetches the containing word and returns the selected lane, right-justified. A narrow write becomes a read-modify-write of the containing word. A full-word write goes straight through.

Two registers need special handling. A halfword write to the transfer-mode offset is not sent downstream. Its merged word is held in an internal shadow. A later halfword write to the command offset merges into that shadow in place of a fresh read. Both halves then reach the peripheral in a single 32-bit write.

The peripheral can drop register writes that arrive too close together. For this reason, every downstream write is held back until a programmable number of clock cycles has passed since the previous one. Reads are never held back.

The host raises `host_req` with its command fields and holds them until `host_ready` pulses for one cycle. Only one transaction is in flight at a time.

Top module: `subword_write_bridge`

## Requirements
- R1: Every downstream strobe (`pr_rd` or `pr_wr`) carries `pr_addr` equal to `host_addr` with bits [1:0] forced to zero.
- R2: A read (`host_we`=0) raises `pr_rd` for exactly one cycle. `host_size` encodes the access width: 0 is a byte, 1 is a halfword, 2 or 3 is a word. For a byte, the lane is `host_addr[1:0]` and the result is word >> (8 × lane) masked to 8 bits. For a halfword, the result is word >> (16 × `host_addr[1]`) masked to 16 bits. For a word, the result is the whole word. `host_rdata` is zero above the access width.
- R3: A word write raises no `pr_rd` and produces one `pr_wr` with `pr_wdata` equal to `host_wdata`.
- R4: A byte write, or a halfword write to any offset other than XFER_OFS and CMD_OFS, first raises `pr_rd` for one cycle. It then produces one `pr_wr` whose word equals the read word with the target lane replaced by the new value. `pr_rd` and `pr_wr` are never high together.
- R5: A halfword write to XFER_OFS reads the containing word and raises no `pr_wr`. The merged word is kept in the shadow.
- R6: A halfword write to CMD_OFS raises no `pr_rd`. It writes one word formed from the shadow with the addressed half replaced. The shadow keeps its value afterwards.
- R7: Two cycles that carry `pr_wr` are at least GAP_CYCLES cycles apart. A write that is ready earlier is held and issues in the first cycle the gap allows.
- R8: Reads neither wait on the gap nor restart it.
- R9: `host_ready` is a one-cycle pulse. With the request seen in cycle k, it comes at k+2 for a read or a transfer-mode write. For other writes it comes one cycle after the `pr_wr` cycle. That `pr_wr` cycle is nominally k+1 for word and command writes and k+2 for read-modify-write.
- R10: During and after reset, `host_ready`, `pr_rd` and `pr_wr` are low. The shadow is zero, and the first write after reset is not held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_req | input | 1 | Host transaction request, held until `host_ready` |
| host_we | input | 1 | 1 = write, 0 = read |
| host_size | input | 2 | 0 byte, 1 halfword, 2/3 word |
| host_addr | input | AW | Byte address of the access |
| host_wdata | input | 32 | Write value, right-justified |
| host_ready | output | 1 | One-cycle completion pulse |
| host_rdata | output | 32 | Read result, valid with `host_ready` |
| pr_rd | output | 1 | Downstream word read strobe |
| pr_wr | output | 1 | Downstream word write strobe |
| pr_addr | output | AW | Word-aligned downstream address |
| pr_wdata | output | 32 | Downstream write word |
| pr_rdata | input | 32 | Downstream read word, valid in the `pr_rd` cycle |

## Verification
The bench builds the bridge with AW=8 and GAP_CYCLES=5, while the default gap is 300 cycles. With a gap that short, the bench can issue back-to-back writes that must be held, and can also leave idle stretches after which a write must not be held. It can also interleave reads inside a pending gap. A shadow of the full 8-bit address space fits in a 64-word model memory, so the merged contents of every touched word can be compared.

// File: rtl/subword_write_bridge.sv
module subword_write_bridge #(
  parameter int AW = 8,
  parameter int GAP_CYCLES = 300,
  parameter logic [AW-1:0] XFER_OFS = 'h0C,
  parameter logic [AW-1:0] CMD_OFS = 'h0E
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_req,
  input  logic          host_we,
  input  logic [1:0]    host_size,
  input  logic [AW-1:0] host_addr,
  input  logic [31:0]   host_wdata,
  output logic          host_ready,
  output logic [31:0]   host_rdata,
  output logic          pr_rd,
  output logic          pr_wr,
  output logic [AW-1:0] pr_addr,
  output logic [31:0]   pr_wdata,
  input  logic [31:0]   pr_rdata
);
  localparam int CW = $clog2(GAP_CYCLES + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_WRITE, ST_ACK} st_t;

  st_t           st;
  logic [AW-1:0] a_addr;
  logic [1:0]    a_size;
  logic          a_we, a_xfer;
  logic [31:0]   a_ins, a_mask;
  logic [4:0]    a_shift;
  logic [31:0]   shadow, wword, rword;
  logic [CW-1:0] gap_cnt;

  function automatic logic [4:0] lane_shift(input logic [1:0] sz, input logic [1:0] lo);
    case (sz)
      2'd0:    lane_shift = {lo, 3'b000};
      2'd1:    lane_shift = {lo[1], 4'b0000};
      default: lane_shift = 5'd0;
    endcase
  endfunction

  function automatic logic [31:0] lane_mask(input logic [1:0] sz, input logic [1:0] lo);
    case (sz)
      2'd0:    lane_mask = 32'h0000_00FF << lane_shift(sz, lo);
      2'd1:    lane_mask = 32'h0000_FFFF << lane_shift(sz, lo);
      default: lane_mask = 32'hFFFF_FFFF;
    endcase
  endfunction

  logic [31:0] h_mask, h_ins;
  logic        h_half, h_xfer, h_cmd;

  assign h_mask = lane_mask(host_size, host_addr[1:0]);
  assign h_ins  = (host_wdata << lane_shift(host_size, host_addr[1:0])) & h_mask;
  assign h_half = (host_size == 2'd1);
  assign h_xfer = host_we && h_half && (host_addr == XFER_OFS);
  assign h_cmd  = host_we && h_half && (host_addr == CMD_OFS);

  assign a_mask  = lane_mask(a_size, a_addr[1:0]);
  assign a_shift = lane_shift(a_size, a_addr[1:0]);

  logic [31:0] rmw_word;
  assign rmw_word = (pr_rdata & ~a_mask) | a_ins;

  assign pr_rd      = (st == ST_READ);
  assign pr_wr      = (st == ST_WRITE) && (gap_cnt == '0);
  assign pr_addr    = {a_addr[AW-1:2], 2'b00};
  assign pr_wdata   = wword;
  assign host_ready = (st == ST_ACK);
  assign host_rdata = rword;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      a_addr <= '0;
      a_size <= '0;
      a_we   <= 1'b0;
      a_xfer <= 1'b0;
      a_ins  <= '0;
      shadow <= '0;
      wword  <= '0;
      rword  <= '0;
    end else begin
      case (st)
        ST_IDLE: if (host_req) begin
          a_addr <= host_addr;
          a_size <= host_size;
          a_we   <= host_we;
          a_xfer <= h_xfer;
          a_ins  <= h_ins;
          if (host_we && host_size[1]) begin
            wword <= host_wdata;
            st    <= ST_WRITE;
          end else if (h_cmd) begin
            wword <= (shadow & ~h_mask) | h_ins;
            st    <= ST_WRITE;
          end else begin
            st <= ST_READ;
          end
        end
        ST_READ: begin
          if (!a_we) begin
            rword <= (pr_rdata & a_mask) >> a_shift;
            st    <= ST_ACK;
          end else if (a_xfer) begin
            shadow <= rmw_word;
            st     <= ST_ACK;
          end else begin
            wword <= rmw_word;
            st    <= ST_WRITE;
          end
        end
        ST_WRITE: if (pr_wr) st <= ST_ACK;
        default:  st <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)              gap_cnt <= '0;
    else if (pr_wr)          gap_cnt <= CW'(GAP_CYCLES - 1);
    else if (gap_cnt != '0)  gap_cnt <= gap_cnt - 1'b1;
  end
endmodule

// File: rtl/subword_write_bridge_checker.sv
module subword_write_bridge_checker #(
  parameter int AW = 8,
  parameter int GAP_CYCLES = 300
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pr_rd,
  input logic          pr_wr,
  input logic [AW-1:0] pr_addr,
  input logic          host_ready
);
  localparam int SW = $clog2(GAP_CYCLES + 1) + 1;

  logic [SW-1:0] since_wr;

  always_ff @(posedge clk) begin
    if (!rst_n)                        since_wr <= SW'(GAP_CYCLES);
    else if (pr_wr)                    since_wr <= SW'(1);
    else if (since_wr < SW'(GAP_CYCLES)) since_wr <= since_wr + 1'b1;
  end

  AST_ALIGNED_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (pr_rd || pr_wr) |-> (pr_addr[1:0] == 2'b00)); // R1
  AST_RD_WR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(pr_rd && pr_wr)); // R4
  AST_MIN_WRITE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    pr_wr |-> (since_wr >= SW'(GAP_CYCLES))); // R7
  AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    host_ready |=> !host_ready); // R9
  AST_READ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    pr_rd |=> !pr_rd); // R2
endmodule

bind subword_write_bridge subword_write_bridge_checker #(.AW(AW), .GAP_CYCLES(GAP_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .pr_rd(pr_rd), .pr_wr(pr_wr),
  .pr_addr(pr_addr), .host_ready(host_ready)
);

// File: tb/test_subword_write_bridge.sv
module test_subword_write_bridge;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int GAP = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_req = 1'b0, host_we = 1'b0;
  logic [1:0]  host_size = 2'd0;
  logic [7:0]  host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic        host_ready, pr_rd, pr_wr;
  logic [31:0] host_rdata, pr_wdata, pr_rdata;
  logic [7:0]  pr_addr;

  logic [31:0] pmem [64];
  logic [31:0] ref_mem [64];
  logic [31:0] ref_shadow = '0;
  int ref_last_w = -100000;
  int cyc = 0, n_chk = 0, n_fail = 0;
  int wr_cnt = 0, rd_cnt = 0, obs_last_w = -100000;
  logic [31:0] obs_last_data = '0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  subword_write_bridge #(.AW(AW), .GAP_CYCLES(GAP)) i_subword_write_bridge (
    .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
    .host_size(host_size), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_ready(host_ready), .host_rdata(host_rdata), .pr_rd(pr_rd), .pr_wr(pr_wr),
    .pr_addr(pr_addr), .pr_wdata(pr_wdata), .pr_rdata(pr_rdata)
  );

  assign pr_rdata = pmem[pr_addr[7:2]];
  always @(posedge clk) if (pr_wr) pmem[pr_addr[7:2]] <= pr_wdata;

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  // per-clock monitor: alignment and write spacing
  always @(negedge clk) if (rst_n) begin
    if (pr_rd || pr_wr) chk(pr_addr[1:0] == 2'b00, "R1", "aligned address", {24'h0, pr_addr}, {24'h0, pr_addr & 8'hFC});
    if (pr_rd && pr_wr) chk(0, "R4", "read and write together", 32'h1, 32'h0);
    if (pr_wr) begin
      chk(cyc - obs_last_w >= GAP, "R7", "write spacing", 32'(cyc - obs_last_w), 32'(GAP));
      obs_last_w = cyc;
      obs_last_data = pr_wdata;
      wr_cnt++;
    end
    if (pr_rd) rd_cnt++;
  end

  task automatic txn(input bit we, input logic [1:0] sz, input logic [7:0] a,
                     input logic [31:0] wd, input string rq);
    int k0, exp_ack, exp_w, nominal, wr0, rd0, idx, sh, guard;
    logic [31:0] m, ins, newv, exp_rd;
    bit do_rd, do_wr, half, xfer, cmd;
    idx = int'(a[7:2]);
    sh  = (sz == 2'd0) ? 8 * int'(a[1:0]) : (sz == 2'd1) ? 16 * int'(a[1]) : 0;
    m   = (sz == 2'd0) ? 32'hFF << sh : (sz == 2'd1) ? 32'hFFFF << sh : 32'hFFFF_FFFF;
    ins = (wd << sh) & m;
    half = (sz == 2'd1);
    xfer = we && half && (a == 8'h0C);
    cmd  = we && half && (a == 8'h0E);
    @(negedge clk);
    k0 = cyc;
    host_req = 1'b1; host_we = we; host_size = sz; host_addr = a; host_wdata = wd;
    wr0 = wr_cnt; rd0 = rd_cnt;
    do_rd = 1; do_wr = 0; exp_rd = '0; newv = '0; nominal = 0;
    if (!we) begin
      exp_rd = (ref_mem[idx] & m) >> sh;
      exp_ack = k0 + 2;
    end else if (sz[1]) begin
      do_rd = 0; do_wr = 1; newv = wd; nominal = k0 + 1;
    end else if (cmd) begin
      do_rd = 0; do_wr = 1; newv = (ref_shadow & ~m) | ins; nominal = k0 + 1;
    end else begin
      newv = (ref_mem[idx] & ~m) | ins;
      if (xfer) begin
        ref_shadow = newv; exp_ack = k0 + 2;
      end else begin
        do_wr = 1; nominal = k0 + 2;
      end
    end
    exp_w = 0;
    if (do_wr) begin
      exp_w = (nominal > ref_last_w + GAP) ? nominal : ref_last_w + GAP;
      exp_ack = exp_w + 1;
      ref_last_w = exp_w;
      ref_mem[idx] = newv;
    end
    guard = 0;
    do begin
      @(negedge clk);
      guard++;
    end while (!host_ready && guard < 1000);
    chk(cyc == exp_ack, rq, "ready cycle", 32'(cyc - k0), 32'(exp_ack - k0));
    if (!we) chk(host_rdata == exp_rd, rq, "read data", host_rdata, exp_rd);
    host_req = 1'b0;
    chk(wr_cnt - wr0 == int'(do_wr), rq, "write count", 32'(wr_cnt - wr0), 32'(do_wr));
    chk(rd_cnt - rd0 == int'(do_rd), rq, "read count", 32'(rd_cnt - rd0), 32'(do_rd));
    if (do_wr) begin
      chk(obs_last_data == newv, rq, "written word", obs_last_data, newv);
      chk(obs_last_w == exp_w, rq, "write cycle", 32'(obs_last_w - k0), 32'(exp_w - k0));
    end
    @(negedge clk);
    chk(pmem[idx] == ref_mem[idx], rq, "peripheral word", pmem[idx], ref_mem[idx]);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      chk(0, "WD", "watchdog expired", 32'(cyc), 32'h0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) begin
      pmem[i] = 32'(i) * 32'h0103_0507 ^ 32'hA55A_3CC3;
      ref_mem[i] = pmem[i];
    end
    repeat (3) @(negedge clk);
    chk(!host_ready && !pr_rd && !pr_wr, "R10", "outputs in reset",
        {29'h0, host_ready, pr_rd, pr_wr}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!host_ready && !pr_rd && !pr_wr, "R10", "outputs after reset",
        {29'h0, host_ready, pr_rd, pr_wr}, 32'h0);
    // R10 R6: command write straight after reset: zero shadow, no hold
    txn(1, 2'd1, 8'h0E, 32'h0000_BEEF, "R10");
    // R3 R7: word write right behind it must be held
    txn(1, 2'd2, 8'h10, 32'h1122_3344, "R3");
    // R2: reads of every width and lane
    txn(0, 2'd2, 8'h10, 0, "R2");
    for (int l = 0; l < 4; l++) txn(0, 2'd0, 8'h10 + 8'(l), 0, "R2");
    txn(0, 2'd1, 8'h12, 0, "R2");
    txn(0, 2'd1, 8'h10, 0, "R2");
    txn(0, 2'd1, 8'h2A, 0, "R2");
    // R4: byte and halfword read-modify-write
    txn(1, 2'd0, 8'h21, 32'hFFFF_FF5A, "R4");
    txn(1, 2'd0, 8'h27, 32'h0000_00C3, "R4");
    txn(1, 2'd1, 8'h22, 32'h1234_9876, "R4");
    txn(1, 2'd1, 8'h30, 32'h0000_4321, "R4");
    // R5 R6: transfer-mode halfword kept, merged into the command write
    txn(1, 2'd1, 8'h0C, 32'h0000_7777, "R5");
    txn(0, 2'd2, 8'h0C, 0, "R5");
    txn(1, 2'd1, 8'h0E, 32'h0000_0A0B, "R6");
    txn(1, 2'd1, 8'h0E, 32'h0000_0C0D, "R6");
    // byte write to the transfer-mode offset is a plain read-modify-write
    txn(1, 2'd0, 8'h0C, 32'h0000_0099, "R4");
    // R8: reads inside a pending gap neither wait nor restart it
    txn(1, 2'd2, 8'h40, 32'hDEAD_BEEF, "R8");
    txn(0, 2'd0, 8'h41, 0, "R8");
    txn(0, 2'd2, 8'h40, 0, "R8");
    txn(1, 2'd2, 8'h44, 32'hCAFE_F00D, "R8");
    // R7: after a long idle stretch the write is not held
    repeat (2 * GAP) @(negedge clk);
    txn(1, 2'd2, 8'hFC, 32'h0F0F_0F0F, "R7");
    txn(1, 2'd0, 8'hFE, 32'h0000_00E1, "R7");
    // R9: back-to-back narrow writes queue behind the gap
    txn(1, 2'd1, 8'h52, 32'h0000_ABCD, "R9");
    txn(1, 2'd0, 8'h53, 32'h0000_0011, "R9");
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule